// File: doc/BRIEF.md
# Data Address Generator for a DSP Core

This unit produces 16-bit data-memory addresses for a signal-processing core. It holds four pointer registers, two signed step registers, a base register for direct addressing and a pair of bound registers that set up a circular buffer. Each cycle the core may present one address request. The request names an access mode, a pointer, a step code and a 5-bit offset. The unit then returns the effective address in the same cycle and updates the chosen pointer at the next clock edge.

Software loads the registers through a write port. A write is either a full 16-bit load or a 9-bit short load. Any register can be read back through a combinational read port. Three request modes are provided: pointer-indirect with a post-step, direct (base plus offset), and compound-access with a wider set of post-steps. Circular wrapping applies to both pointer modes while the upper bound register holds a nonzero value. The unit does not include the memory, the data exchange performed by compound instructions, or the segment and bank decoding.

Top module: `dag_unit`

## Requirements
- R1: While reset is active, and after it is released, every register reads back zero. Register select codes are: pointers 0 to 3, step J = 4, step K = 5, base = 6, lower bound = 7, upper bound = 8.
- R2: A full write (wr_short = 0) loads all 16 bits of wr_data into the selected register. A write to select codes 9 to 15 changes nothing, and reading those codes returns zero.
- R3: A short write (wr_short = 1) loads wr_data[8:0] into the low 9 bits of the register. Bits 15:9 are filled with zeros for the pointers and the bound registers. For steps J and K they are copies of bit 8.
- R4: A short write that targets the base register is ignored.
- R5: In indirect mode (req_mode = 0), addr_out equals the chosen pointer before its step. Step codes 0, 1, 2 and 3 apply 0, +1, -1 and +J. Codes 4 to 7 leave the pointer unchanged.
- R6: In compound mode (req_mode = 2), addr_out equals the pointer before its step. Step codes 0 to 5 apply 0, +1, -1, +J, +2 and +K. Codes 6 and 7 leave the pointer unchanged.
- R7: Pointer steps that do not wrap use modulo-65536 arithmetic.
- R8: In direct mode (req_mode = 1), addr_out is base[15:5] concatenated with req_offset[4:0], and no pointer changes.
- R9: While the upper bound is nonzero, a +1 step (code 1) of a pointer equal to the upper bound loads the lower bound instead. Every other step, and every step while the upper bound is zero, is plain arithmetic.
- R10: When a write and a post-step target the same pointer in one cycle, the written value is kept.
- R11: addr_valid is high only when req_valid is high and req_mode is 0, 1 or 2. Mode 3, and any cycle with req_valid low, produce no access and change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_short | input | 1 | 1 = 9-bit short load, 0 = full 16-bit load |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 16 | Read data (combinational) |
| req_valid | input | 1 | Address request strobe |
| req_mode | input | 2 | 0 indirect, 1 direct, 2 compound, 3 none |
| req_ptr | input | 2 | Pointer select |
| req_mod | input | 3 | Post-step code |
| req_offset | input | 5 | Direct-mode offset |
| addr_valid | output | 1 | Effective address is valid |
| addr_out | output | 16 | Effective address |

## Verification
The wrap case is the hardest state to reach from the ports. To reach it, the upper bound must be nonzero, a pointer must sit exactly on that bound, and a +1 step must arrive while no write targets that pointer. The stimulus gets there in a fixed order: it loads both bounds, parks a pointer one below the upper bound, and then steps it twice. It then repeats the approach with a +2 step, and again after clearing the upper bound, to show that only the +1 step wraps. A separate directed cycle sends a write and a step to the same pointer together.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int NUM_PTR = 4;
    localparam int PTR_W   = $clog2(NUM_PTR);
    localparam int SEL_W   = $clog2(NUM_PTR + 5);

    // register select codes: pointers first, then the remaining registers
    localparam logic [SEL_W-1:0] SEL_STEPJ = SEL_W'(NUM_PTR);
    localparam logic [SEL_W-1:0] SEL_STEPK = SEL_W'(NUM_PTR + 1);
    localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(NUM_PTR + 2);
    localparam logic [SEL_W-1:0] SEL_LO    = SEL_W'(NUM_PTR + 3);
    localparam logic [SEL_W-1:0] SEL_HI    = SEL_W'(NUM_PTR + 4);

    typedef enum logic [1:0] {
        MODE_IND  = 2'd0,
        MODE_DIR  = 2'd1,
        MODE_CMP  = 2'd2,
        MODE_NONE = 2'd3
    } acc_mode_e;

    localparam logic [2:0] STEP_HOLD = 3'd0;
    localparam logic [2:0] STEP_INC  = 3'd1;
    localparam logic [2:0] STEP_DEC  = 3'd2;
    localparam logic [2:0] STEP_J    = 3'd3;
    localparam logic [2:0] STEP_INC2 = 3'd4;
    localparam logic [2:0] STEP_K    = 3'd5;

endpackage

// File: rtl/dag_short_ext.sv
module dag_short_ext #(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 9
) (
    input  logic [SHORT_W-1:0] imm,
    input  logic               sign_en,
    output logic [DATA_W-1:0]  value
);
    localparam int FILL_W = DATA_W - SHORT_W;

    logic fill_bit;

    always_comb begin
        fill_bit = sign_en & imm[SHORT_W-1];
        value    = {{FILL_W{fill_bit}}, imm};
    end
endmodule

// File: rtl/dag_step.sv
module dag_step
    import dag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [2:0]        code,
    input  logic              compound,
    input  logic [DATA_W-1:0] step_j,
    input  logic [DATA_W-1:0] step_k,
    input  logic [DATA_W-1:0] bound_lo,
    input  logic [DATA_W-1:0] bound_hi,
    output logic [DATA_W-1:0] nxt
);
    logic [DATA_W-1:0] delta;
    logic              circ_on;
    logic              wrap_hit;

    always_comb begin
        delta = '0;
        case (code)
            STEP_INC:  delta = DATA_W'(1);
            STEP_DEC:  delta = '1;
            STEP_J:    delta = step_j;
            STEP_INC2: delta = compound ? DATA_W'(2) : '0;
            STEP_K:    delta = compound ? step_k : '0;
            default:   delta = '0;
        endcase
        circ_on  = (bound_hi != '0);
        wrap_hit = circ_on && (code == STEP_INC) && (cur == bound_hi);
        nxt      = wrap_hit ? bound_lo : cur + delta;
    end
endmodule

// File: rtl/dag_ea.sv
module dag_ea
    import dag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 5
) (
    input  logic              req_valid,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFF_W-1:0]  offset,
    output logic              valid,
    output logic [DATA_W-1:0] addr
);
    always_comb begin
        valid = req_valid && (mode != MODE_NONE);
        if (mode == MODE_DIR) begin
            addr = {base_val[DATA_W-1:OFF_W], offset};
        end else begin
            addr = ptr_val;
        end
    end
endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 9,
    parameter int OFF_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_short,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                req_valid,
    input  logic [1:0]          req_mode,
    input  logic [PTR_W-1:0]    req_ptr,
    input  logic [2:0]          req_mod,
    input  logic [OFF_W-1:0]    req_offset,
    output logic                addr_valid,
    output logic [DATA_W-1:0]   addr_out
);
    typedef struct packed {
        logic [NUM_PTR-1:0][DATA_W-1:0] ptr;
        logic [DATA_W-1:0]              sj;
        logic [DATA_W-1:0]              sk;
        logic [DATA_W-1:0]              base;
        logic [DATA_W-1:0]              lo;
        logic [DATA_W-1:0]              hi;
    } dag_state_t;

    dag_state_t st_d, st_q;

    logic [DATA_W-1:0] ptr_cur;
    logic [DATA_W-1:0] ptr_nxt;
    logic [DATA_W-1:0] short_val;
    logic [DATA_W-1:0] wr_val;
    logic              sext_sel;
    logic              ptr_step_en;
    logic              wr_is_ptr;

    assign ptr_cur = st_q.ptr[req_ptr];

    dag_short_ext #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_ext (
        .imm     (wr_data[SHORT_W-1:0]),
        .sign_en (sext_sel),
        .value   (short_val)
    );

    dag_step #(.DATA_W(DATA_W)) u_step (
        .cur      (ptr_cur),
        .code     (req_mod),
        .compound (req_mode == MODE_CMP),
        .step_j   (st_q.sj),
        .step_k   (st_q.sk),
        .bound_lo (st_q.lo),
        .bound_hi (st_q.hi),
        .nxt      (ptr_nxt)
    );

    dag_ea #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_ea (
        .req_valid (req_valid),
        .mode      (req_mode),
        .ptr_val   (ptr_cur),
        .base_val  (st_q.base),
        .offset    (req_offset),
        .valid     (addr_valid),
        .addr      (addr_out)
    );

    always_comb begin
        sext_sel    = (wr_sel == SEL_STEPJ) || (wr_sel == SEL_STEPK);
        wr_val      = wr_short ? short_val : wr_data;
        wr_is_ptr   = wr_sel < SEL_W'(NUM_PTR);
        ptr_step_en = req_valid && ((req_mode == MODE_IND) || (req_mode == MODE_CMP));

        st_d = st_q;
        // post-step first, so that a write below overrides it
        if (ptr_step_en) begin
            st_d.ptr[req_ptr] = ptr_nxt;
        end
        if (wr_en) begin
            if (wr_is_ptr) begin
                st_d.ptr[wr_sel[PTR_W-1:0]] = wr_val;
            end else begin
                case (wr_sel)
                    SEL_STEPJ: st_d.sj = wr_val;
                    SEL_STEPK: st_d.sk = wr_val;
                    SEL_BASE:  if (!wr_short) st_d.base = wr_data;
                    SEL_LO:    st_d.lo = wr_val;
                    SEL_HI:    st_d.hi = wr_val;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel < SEL_W'(NUM_PTR)) begin
            rd_data = st_q.ptr[rd_sel[PTR_W-1:0]];
        end else begin
            case (rd_sel)
                SEL_STEPJ: rd_data = st_q.sj;
                SEL_STEPK: rd_data = st_q.sk;
                SEL_BASE:  rd_data = st_q.base;
                SEL_LO:    rd_data = st_q.lo;
                SEL_HI:    rd_data = st_q.hi;
                default:   rd_data = '0;
            endcase
        end
    end

    // a short load of the base register leaves it untouched
    assert_base_short_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_short && wr_sel == SEL_BASE) |=> (st_q.base == $past(st_q.base)));

    // a short load of step J sign-extends from bit SHORT_W-1
    assert_stepj_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_short && wr_sel == SEL_STEPJ)
        |=> (st_q.sj[DATA_W-1:SHORT_W] == {(DATA_W-SHORT_W){st_q.sj[SHORT_W-1]}}));

    // a full write to a pointer wins over any step in the same cycle
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_short && wr_sel == SEL_W'(0)) |=> (st_q.ptr[0] == $past(wr_data)));

    // a direct access without a write leaves every pointer as it was
    assert_direct_holds_ptrs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MODE_DIR && !wr_en) |=> $stable(st_q.ptr));

    // a +1 step from the upper bound lands on the lower bound
    assert_circular_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == MODE_IND && req_mod == STEP_INC && st_q.hi != '0
         && ptr_cur == st_q.hi && !wr_en)
        |=> (st_q.ptr[$past(req_ptr)] == $past(st_q.lo)));

    // no access is flagged while no request is offered
    assert_idle_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !addr_valid);

    // an idle cycle without a write keeps the pointers
    assert_idle_holds_ptrs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wr_en) |=> $stable(st_q.ptr));

endmodule

// File: tb/tb_dag_unit.sv
module tb_dag_unit;
    import dag_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_short = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_ptr = '0;
    logic [2:0]  req_mod = '0;
    logic [4:0]  req_offset = '0;
    logic        addr_valid;
    logic [15:0] addr_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dag_unit dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_short(wr_short), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .req_valid(req_valid), .req_mode(req_mode), .req_ptr(req_ptr),
        .req_mod(req_mod), .req_offset(req_offset),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    // row kinds: full write, short write, request (check address), read (check data)
    localparam logic [1:0] KW = 2'd0, KS = 2'd1, KQ = 2'd2, KD = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  sel;
        logic [15:0] data;
        logic [1:0]  mode;
        logic [2:0]  mod;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 52;
    localparam vec_t VECS [NVEC] = '{
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h0000, 4'd1},  // R1 pointer 0 clear
        '{KD, 4'd8, 16'h0000, 2'd0, 3'd0, 16'h0000, 4'd1},  // R1 upper bound clear
        '{KW, 4'd0, 16'h1000, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd0, 16'h0000, 2'd0, 3'd1, 16'h1000, 4'd5},  // R5 +1
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h1001, 4'd5},
        '{KW, 4'd4, 16'h0010, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd0, 16'h0000, 2'd0, 3'd3, 16'h1001, 4'd5},  // R5 +J
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h1011, 4'd5},
        '{KQ, 4'd0, 16'h0000, 2'd0, 3'd2, 16'h1011, 4'd5},  // R5 -1
        '{KQ, 4'd0, 16'h0000, 2'd0, 3'd4, 16'h1010, 4'd5},  // R5 +2 refused
        '{KQ, 4'd0, 16'h0000, 2'd0, 3'd5, 16'h1010, 4'd5},  // R5 +K refused
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h1010, 4'd5},
        '{KW, 4'd5, 16'hFFFC, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd0, 16'h0000, 2'd2, 3'd5, 16'h1010, 4'd6},  // R6 +K
        '{KQ, 4'd0, 16'h0000, 2'd2, 3'd4, 16'h100C, 4'd6},  // R6 +2
        '{KQ, 4'd0, 16'h0000, 2'd2, 3'd6, 16'h100E, 4'd6},  // R6 code 6 holds
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h100E, 4'd6},
        '{KS, 4'd4, 16'h01F0, 2'd0, 3'd0, 16'h0000, 4'd3},
        '{KD, 4'd4, 16'h0000, 2'd0, 3'd0, 16'hFFF0, 4'd3},  // R3 J sign-extended
        '{KS, 4'd1, 16'hFFFF, 2'd0, 3'd0, 16'h0000, 4'd3},
        '{KD, 4'd1, 16'h0000, 2'd0, 3'd0, 16'h01FF, 4'd3},  // R3 pointer zero-filled
        '{KS, 4'd5, 16'h0070, 2'd0, 3'd0, 16'h0000, 4'd3},
        '{KD, 4'd5, 16'h0000, 2'd0, 3'd0, 16'h0070, 4'd3},  // R3 K positive
        '{KW, 4'd6, 16'hABCD, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KS, 4'd6, 16'h0001, 2'd0, 3'd0, 16'h0000, 4'd4},
        '{KD, 4'd6, 16'h0000, 2'd0, 3'd0, 16'hABCD, 4'd4},  // R4 base unchanged
        '{KQ, 4'd0, 16'h0013, 2'd1, 3'd1, 16'hABD3, 4'd8},  // R8 direct address
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h100E, 4'd8},  // R8 pointer kept
        '{KW, 4'd2, 16'hFFFF, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd2, 16'h0000, 2'd0, 3'd1, 16'hFFFF, 4'd7},  // R7 roll over up
        '{KD, 4'd2, 16'h0000, 2'd0, 3'd0, 16'h0000, 4'd7},
        '{KQ, 4'd2, 16'h0000, 2'd0, 3'd2, 16'h0000, 4'd7},  // R7 roll over down
        '{KD, 4'd2, 16'h0000, 2'd0, 3'd0, 16'hFFFF, 4'd7},
        '{KW, 4'd7, 16'h0200, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KW, 4'd8, 16'h0203, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KW, 4'd3, 16'h0202, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd3, 16'h0000, 2'd0, 3'd1, 16'h0202, 4'd9},
        '{KQ, 4'd3, 16'h0000, 2'd0, 3'd1, 16'h0203, 4'd9},  // R9 at upper bound
        '{KD, 4'd3, 16'h0000, 2'd0, 3'd0, 16'h0200, 4'd9},  // R9 wrapped
        '{KW, 4'd3, 16'h0203, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd3, 16'h0000, 2'd2, 3'd1, 16'h0203, 4'd9},  // R9 compound +1 wraps
        '{KD, 4'd3, 16'h0000, 2'd0, 3'd0, 16'h0200, 4'd9},
        '{KW, 4'd3, 16'h0203, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd3, 16'h0000, 2'd2, 3'd4, 16'h0203, 4'd9},  // R9 +2 no wrap
        '{KD, 4'd3, 16'h0000, 2'd0, 3'd0, 16'h0205, 4'd9},
        '{KW, 4'd8, 16'h0000, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KW, 4'd3, 16'h0203, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KQ, 4'd3, 16'h0000, 2'd0, 3'd1, 16'h0203, 4'd9},
        '{KD, 4'd3, 16'h0000, 2'd0, 3'd0, 16'h0204, 4'd9},  // R9 disabled
        '{KW, 4'd9, 16'h1234, 2'd0, 3'd0, 16'h0000, 4'd2},
        '{KD, 4'd9, 16'h0000, 2'd0, 3'd0, 16'h0000, 4'd2},  // R2 unused code reads 0
        '{KD, 4'd0, 16'h0000, 2'd0, 3'd0, 16'h100E, 4'd2}   // R2 unused write harmless
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_short = 1'b0; req_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [3:0] sel, input logic [15:0] exp, input string tag);
        @(negedge clk);
        idle();
        rd_sel = sel;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: registers read zero while reset is held
        rd_sel = 4'd5;
        #1;
        check("R1 step K during reset", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            idle();
            case (VECS[i].kind)
                KW, KS: begin
                    wr_en    = 1'b1;
                    wr_short = (VECS[i].kind == KS);
                    wr_sel   = VECS[i].sel;
                    wr_data  = VECS[i].data;
                end
                KQ: begin
                    req_valid  = 1'b1;
                    req_mode   = VECS[i].mode;
                    req_ptr    = VECS[i].sel[1:0];
                    req_mod    = VECS[i].mod;
                    req_offset = VECS[i].data[4:0];
                    #1;
                    check($sformatf("R%0d row %0d address", VECS[i].rq, i), addr_out, VECS[i].exp);
                    check($sformatf("R11 row %0d valid", i), {15'd0, addr_valid}, 16'h0001);
                end
                default: begin
                    rd_sel = VECS[i].sel;
                    #1;
                    check($sformatf("R%0d row %0d read", VECS[i].rq, i), rd_data, VECS[i].exp);
                end
            endcase
        end

        // R10: write and +1 step to pointer 0 in the same cycle
        @(negedge clk);
        idle();
        wr_en = 1'b1; wr_short = 1'b0; wr_sel = 4'd0; wr_data = 16'h4444;
        req_valid = 1'b1; req_mode = 2'd0; req_ptr = 2'd0; req_mod = 3'd1;
        #1;
        check("R10 address before write", addr_out, 16'h100E);
        read_reg(4'd0, 16'h4444, "R10 write kept over step");

        // R11: reserved mode gives no access and no step
        @(negedge clk);
        idle();
        req_valid = 1'b1; req_mode = 2'd3; req_ptr = 2'd0; req_mod = 3'd1;
        #1;
        check("R11 mode 3 not valid", {15'd0, addr_valid}, 16'h0000);
        read_reg(4'd0, 16'h4444, "R11 mode 3 no step");

        // R11: request strobe low with a stepping mode
        @(negedge clk);
        idle();
        req_mode = 2'd0; req_ptr = 2'd0; req_mod = 3'd1;
        #1;
        check("R11 idle not valid", {15'd0, addr_valid}, 16'h0000);
        read_reg(4'd0, 16'h4444, "R11 idle no step");

        // R1: reset in mid-run clears loaded registers
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(4'd0, 16'h0000, "R1 pointer after reset");
        read_reg(4'd4, 16'h0000, "R1 step J after reset");
        read_reg(4'd6, 16'h0000, "R1 base after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule